// File: doc/BRIEF.md
# PCI DMA Address Translator

The block converts a 32-bit DMA address issued by a PCI device into a 48-bit crossbar address, a 4-bit target widget number, ordering attributes and a 16-bit read-modify field. The PCI address space is split into three windows by its two top bits. The low quarter is local and is passed through untouched. The second quarter is translated page by page through an internal table of 128 64-bit entries. The upper half is translated through one direct-map register that supplies a segment offset in 2 GB units.

Software loads the table and the direct-map register through a simple register port. A table entry is written in one 64-bit write. It reads back as two 32-bit words, the upper word at the entry's own offset and the lower word 0x1000 bytes above it. The translate port accepts one request per cycle and presents the result one cycle later, together with the window code and an error flag.

Top module: `pci_dma_xlat`

## Requirements
- R1: After reset `xl_vld_o` is 0, every table entry reads back as zero (so every entry is invalid), and the direct-map register reads back as zero.
- R2: The window code on `xl_win_o` is 0 (local) for addresses below 0x4000_0000, 1 (mapped) for 0x4000_0000 to 0x7FFF_FFFF, and 2 (direct) for 0x8000_0000 and above.
- R3: A local-window request returns the input address zero-extended to 48 bits. Target, attributes and read-modify field are zero, and the error flag is 0.
- R4: A mapped-window request uses page index = address bits 29:12 and entry bits 47:12 as the crossbar page. The output address is {entry[47:12], address[11:0]}.
- R5: On a valid mapped hit, `xl_tgt_o` = entry[11:8] and `xl_rmf_o` = entry[63:48]. `xl_attr_o[0..3]` = coherent, precise, prefetch and barrier, taken from entry bits 1, 2, 3 and 4. Entry bit 0 is the valid bit.
- R6: A mapped request whose page index is 128 or more, or whose entry has bit 0 clear, sets `xl_err_o`. In that case address, target, attributes and read-modify field are all zero. Only mapped requests ever set the error flag.
- R7: With `reg_wr_i` at an 8-byte-aligned offset idx*8 (idx < 128, offset bit 12 clear), the entry is written with all 64 bits of `reg_wdata_i`. A read at that offset returns bits 63:32. A read at offset + 0x1000 returns bits 31:0. Writes into the +0x1000 region are ignored.
- R8: A write at offset 0x800 loads the direct-map register from `reg_wdata_i` as follows: bits 16:0 are the offset, bit 17 is the add-512 flag, bit 18 is the 64-bit read-modify flag, and bits 23:20 are the target. It reads back in the same positions, with every other bit 0. Unmapped offsets read 0.
- R9: A direct-window request returns (offset << 31) + address[30:0] + `DIRECT_BASE` + (add-512 ? 0x2000_0000 : 0), modulo 2^48. The target comes from the register, the attributes are 0, and `xl_rmf_o` = {15'b0, 64-bit flag}.
- R10: Each result appears on the cycle after `xl_req_i` with `xl_vld_o` high. `xl_vld_o` is low in a cycle that follows no request.
- R11: A translation requested in the same cycle as a register write that changes the entry or direct-map register it uses is computed from the previous contents. The next request sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 13 | Register byte offset (write and combinational read) |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| xl_req_i | input | 1 | Translate request |
| xl_addr_i | input | 32 | PCI-side DMA address |
| xl_vld_o | output | 1 | Result valid |
| xl_win_o | output | 2 | Window code |
| xl_err_o | output | 1 | Invalid-address error |
| xl_addr_o | output | 48 | Crossbar address |
| xl_tgt_o | output | 4 | Target widget number |
| xl_attr_o | output | 4 | {barrier, prefetch, precise, coherent} |
| xl_rmf_o | output | 16 | Read-modify field |

## Verification
A software update of the table or the direct-map register can land in the same cycle as a translation that uses it. The bench provokes this by driving a table write and a mapped request to the same index on one clock edge, and likewise a direct-map write together with a direct request. It requires the result of that edge to carry the old target and address. It then issues a second request and requires that result to carry the new values.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int XADDR_W    = 48;
  localparam int REG_AW     = 13;
  localparam logic [REG_AW-1:0] DMAP_OFF = 13'h0800;
  localparam logic [XADDR_W-1:0] ADD512_BYTES = 48'h0000_2000_0000;

  typedef enum logic [1:0] {
    WIN_LOCAL  = 2'd0,
    WIN_MAPPED = 2'd1,
    WIN_DIRECT = 2'd2
  } win_e;

  typedef struct packed {
    logic [15:0] rmf;
    logic [35:0] page;
    logic [3:0]  tgt;
    logic [2:0]  rsvd;
    logic        barrier;
    logic        prefetch;
    logic        precise;
    logic        coherent;
    logic        valid;
  } entry_t;

  // lookup view without reserved bits
  typedef struct packed {
    logic [15:0] rmf;
    logic [35:0] page;
    logic [3:0]  tgt;
    logic [3:0]  attr;
    logic        valid;
  } lookup_t;

  typedef struct packed {
    logic [3:0]  tgt;
    logic        rmf64;
    logic        add512;
    logic [16:0] off;
  } dmap_t;
endpackage

// File: rtl/xlat_entry_table.sv
module xlat_entry_table
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 128,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  entry_t           wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output entry_t           rd_entry_o,
  input  logic [IDX_W-1:0] lk_idx_i,
  output lookup_t          lk_o
);
  entry_t tbl_q [ENTRIES];
  entry_t lk_ent;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
    end else if (wr_en_i) begin
      tbl_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_entry_o = tbl_q[rd_idx_i];
  assign lk_ent     = tbl_q[lk_idx_i];

  always_comb begin
    lk_o.rmf   = lk_ent.rmf;
    lk_o.page  = lk_ent.page;
    lk_o.tgt   = lk_ent.tgt;
    lk_o.attr  = {lk_ent.barrier, lk_ent.prefetch, lk_ent.precise, lk_ent.coherent};
    lk_o.valid = lk_ent.valid;
  end

  AST_TBL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(lk_idx_i) -> $stable(lk_o))); // R7
endmodule

// File: rtl/xlat_direct_reg.sv
module xlat_direct_reg
  import xlat_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [3:0]  tgt_i,
  input  logic        rmf64_i,
  input  logic        add512_i,
  input  logic [16:0] off_i,
  output dmap_t       q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= '{tgt: tgt_i, rmf64: rmf64_i, add512: add512_i, off: off_i};
  end

  AST_DMAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o)); // R8
endmodule

// File: rtl/xlat_win_decode.sv
module xlat_win_decode
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 128,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PIDX_W = 30 - PAGE_SHIFT
) (
  input  logic [31:0]      addr_i,
  output win_e             win_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             idx_ok_o
);
  localparam logic [PIDX_W-1:0] ENT_LIM = PIDX_W'(ENTRIES);
  logic [PIDX_W-1:0] pidx;

  assign pidx     = addr_i[29:PAGE_SHIFT];
  assign idx_o    = pidx[IDX_W-1:0];
  assign idx_ok_o = pidx < ENT_LIM;

  always_comb begin
    if (addr_i[31])      win_o = WIN_DIRECT;
    else if (addr_i[30]) win_o = WIN_MAPPED;
    else                 win_o = WIN_LOCAL;
  end
endmodule

// File: rtl/pci_dma_xlat.sv
module pci_dma_xlat
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter logic [47:0] DIRECT_BASE = 48'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [12:0] reg_addr_i,
  input  logic [63:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        xl_req_i,
  input  logic [31:0] xl_addr_i,
  output logic        xl_vld_o,
  output logic [1:0]  xl_win_o,
  output logic        xl_err_o,
  output logic [47:0] xl_addr_o,
  output logic [3:0]  xl_tgt_o,
  output logic [3:0]  xl_attr_o,
  output logic [15:0] xl_rmf_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [8:0] ENT_LIM = 9'(ENTRIES);

  // register port decode
  logic             in_tbl, tbl_we, dmap_we;
  logic [IDX_W-1:0] reg_idx;
  entry_t           rd_entry;
  dmap_t            dmap;

  assign in_tbl  = (reg_addr_i[11:3] < ENT_LIM) && (reg_addr_i[2:0] == 3'b0);
  assign reg_idx = reg_addr_i[3 +: IDX_W];
  assign tbl_we  = reg_wr_i && in_tbl && !reg_addr_i[12];
  assign dmap_we = reg_wr_i && (reg_addr_i == DMAP_OFF);

  always_comb begin
    if (in_tbl)                        reg_rdata_o = reg_addr_i[12] ? rd_entry[31:0] : rd_entry[63:32];
    else if (reg_addr_i == DMAP_OFF)   reg_rdata_o = {8'b0, dmap.tgt, 1'b0, dmap.rmf64, dmap.add512, dmap.off};
    else                               reg_rdata_o = '0;
  end

  // translate path
  win_e             win;
  logic [IDX_W-1:0] lk_idx;
  logic             idx_ok;
  lookup_t          lk;

  xlat_win_decode #(.ENTRIES(ENTRIES)) u_dec (
    .addr_i   (xl_addr_i),
    .win_o    (win),
    .idx_o    (lk_idx),
    .idx_ok_o (idx_ok)
  );

  xlat_entry_table #(.ENTRIES(ENTRIES)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (tbl_we),
    .wr_idx_i   (reg_idx),
    .wr_data_i  (entry_t'(reg_wdata_i)),
    .rd_idx_i   (reg_idx),
    .rd_entry_o (rd_entry),
    .lk_idx_i   (lk_idx),
    .lk_o       (lk)
  );

  xlat_direct_reg u_dmap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (dmap_we),
    .tgt_i    (reg_wdata_i[23:20]),
    .rmf64_i  (reg_wdata_i[18]),
    .add512_i (reg_wdata_i[17]),
    .off_i    (reg_wdata_i[16:0]),
    .q_o      (dmap)
  );

  logic        nx_err;
  logic [47:0] nx_addr, dir_addr;
  logic [3:0]  nx_tgt, nx_attr;
  logic [15:0] nx_rmf;

  assign dir_addr = (XADDR_W'(dmap.off) << 31) + XADDR_W'(xl_addr_i[30:0]) + DIRECT_BASE
                  + (dmap.add512 ? ADD512_BYTES : '0);

  always_comb begin
    nx_err  = 1'b0;
    nx_addr = '0;
    nx_tgt  = '0;
    nx_attr = '0;
    nx_rmf  = '0;
    unique case (win)
      WIN_LOCAL: nx_addr = XADDR_W'(xl_addr_i);
      WIN_MAPPED: begin
        if (idx_ok && lk.valid) begin
          nx_addr = {lk.page, xl_addr_i[PAGE_SHIFT-1:0]};
          nx_tgt  = lk.tgt;
          nx_attr = lk.attr;
          nx_rmf  = lk.rmf;
        end else begin
          nx_err = 1'b1;
        end
      end
      default: begin
        nx_addr = dir_addr;
        nx_tgt  = dmap.tgt;
        nx_rmf  = {15'b0, dmap.rmf64};
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xl_vld_o  <= 1'b0;
      xl_win_o  <= WIN_LOCAL;
      xl_err_o  <= 1'b0;
      xl_addr_o <= '0;
      xl_tgt_o  <= '0;
      xl_attr_o <= '0;
      xl_rmf_o  <= '0;
    end else begin
      xl_vld_o <= xl_req_i;
      if (xl_req_i) begin
        xl_win_o  <= win;
        xl_err_o  <= nx_err;
        xl_addr_o <= nx_addr;
        xl_tgt_o  <= nx_tgt;
        xl_attr_o <= nx_attr;
        xl_rmf_o  <= nx_rmf;
      end
    end
  end

  AST_VLD_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_req_i |=> xl_vld_o); // R10
  AST_NO_VLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xl_req_i |=> !xl_vld_o); // R10
  AST_ERR_MAPPED_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_vld_o && xl_err_o) |-> (xl_win_o == WIN_MAPPED)); // R6
  AST_ERR_ZERO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_vld_o && xl_err_o) |-> (xl_addr_o == '0 && xl_tgt_o == '0 && xl_attr_o == '0 && xl_rmf_o == '0)); // R6
  AST_LOCAL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_req_i && !xl_addr_i[31] && !xl_addr_i[30]) |=> (xl_addr_o == 48'($past(xl_addr_i)) && !xl_err_o)); // R3
  AST_DIRECT_NO_ATTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_vld_o && xl_win_o == WIN_DIRECT) |-> (xl_attr_o == '0 && !xl_err_o)); // R9
endmodule

// File: tb/pci_dma_xlat_tb.sv
module pci_dma_xlat_tb;
  localparam logic [47:0] BASE = 48'h0000_1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [12:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xl_req = 1'b0;
  logic [31:0] xl_addr = '0;
  logic        xl_vld, xl_err;
  logic [1:0]  xl_win;
  logic [47:0] xl_addr_o;
  logic [3:0]  xl_tgt, xl_attr;
  logic [15:0] xl_rmf;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pci_dma_xlat #(.ENTRIES(128), .DIRECT_BASE(BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .xl_req_i(xl_req), .xl_addr_i(xl_addr), .xl_vld_o(xl_vld), .xl_win_o(xl_win),
    .xl_err_o(xl_err), .xl_addr_o(xl_addr_o), .xl_tgt_o(xl_tgt), .xl_attr_o(xl_attr),
    .xl_rmf_o(xl_rmf)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_ent(logic [15:0] rmf, logic [35:0] pg, logic [3:0] tgt,
                                         logic [4:0] flags);
    return {rmf, pg, tgt, 3'b000, flags};
  endfunction

  task automatic reg_write(logic [12:0] a, logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [12:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic xlate(logic [31:0] a);
    @(negedge clk);
    xl_req = 1'b1; xl_addr = a;
    @(negedge clk);
    xl_req = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 vld", {63'b0, xl_vld}, 64'd0);
    reg_read(13'h0000, d);  chk("R1 entry0 hi", {32'b0, d}, 64'd0);
    reg_read(13'h13F8, d);  chk("R1 entry127 lo", {32'b0, d}, 64'd0);
    reg_read(13'h0800, d);  chk("R1 dmap", {32'b0, d}, 64'd0);
    xlate(32'h4000_0123);
    chk("R1 entry0 invalid", {63'b0, xl_err}, 64'd1);
  endtask

  task automatic t_reg_rw;
    logic [31:0] d;
    reg_write(13'h0028, 64'hABCD_0012_3456_7A1F);
    reg_read(13'h0028, d);  chk("R7 upper half", {32'b0, d}, 64'hABCD_0012);
    reg_read(13'h1028, d);  chk("R7 lower half", {32'b0, d}, 64'h3456_7A1F);
    reg_write(13'h1028, 64'h0);
    reg_read(13'h1028, d);  chk("R7 lower region write ignored", {32'b0, d}, 64'h3456_7A1F);
    reg_write(13'h0800, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_read(13'h0800, d);  chk("R8 dmap readback", {32'b0, d}, 64'h00F7_FFFF);
    reg_read(13'h0C00, d);  chk("R8 unmapped reads 0", {32'b0, d}, 64'd0);
  endtask

  task automatic t_local;
    xlate(32'h3FFF_FFFC);
    chk("R2 local win", {62'b0, xl_win}, 64'd0);
    chk("R3 local addr", {16'b0, xl_addr_o}, 64'h3FFF_FFFC);
    chk("R3 local attrs", {40'b0, xl_tgt, xl_attr, xl_rmf, xl_err}, 64'd0);
    xlate(32'h0000_0000);
    chk("R3 local zero", {16'b0, xl_addr_o}, 64'd0);
  endtask

  task automatic t_mapped;
    logic [63:0] e5 = mk_ent(16'h1234, 36'h9_8765_4321, 4'hA, 5'b10101);
    logic [63:0] e7 = mk_ent(16'hBEEF, 36'hF_0000_0001, 4'h5, 5'b01011);
    reg_write(13'h0028, e5);
    reg_write(13'h03F8, e7);
    xlate(32'h4000_5ABC);
    chk("R2 mapped win", {62'b0, xl_win}, 64'd1);
    chk("R4 mapped addr", {16'b0, xl_addr_o}, {16'b0, 36'h9_8765_4321, 12'hABC});
    chk("R5 tgt", {60'b0, xl_tgt}, 64'hA);
    chk("R5 attr", {60'b0, xl_attr}, 64'b1010);
    chk("R5 rmf", {48'b0, xl_rmf}, 64'h1234);
    chk("R6 no err on hit", {63'b0, xl_err}, 64'd0);
    xlate(32'h4007_F001);
    chk("R4 last entry addr", {16'b0, xl_addr_o}, {16'b0, 36'hF_0000_0001, 12'h001});
    chk("R5 last entry attr", {60'b0, xl_attr}, 64'b0101);
    xlate(32'h4008_0000);
    chk("R6 index 128 err", {63'b0, xl_err}, 64'd1);
    chk("R6 index 128 zero", {xl_addr_o, xl_tgt, xl_attr, 8'b0}, 64'd0);
    xlate(32'h7FFF_FFFF);
    chk("R6 top of window err", {61'b0, xl_win, xl_err}, 64'b011);
    xlate(32'h4000_6000);
    chk("R6 invalid entry err", {63'b0, xl_err}, 64'd1);
    chk("R6 invalid entry rmf", {48'b0, xl_rmf}, 64'd0);
  endtask

  task automatic t_direct;
    reg_write(13'h0800, {32'b0, 8'h00, 4'h7, 1'b0, 1'b1, 1'b1, 17'h1_0003});
    xlate(32'h8000_0010);
    chk("R2 direct win", {62'b0, xl_win}, 64'd2);
    chk("R9 direct addr add512", {16'b0, xl_addr_o},
        {16'b0, (48'h1_0003 << 31) + 48'h10 + BASE + 48'h2000_0000});
    chk("R9 direct tgt", {60'b0, xl_tgt}, 64'h7);
    chk("R9 direct rmf/attr", {44'b0, xl_attr, xl_rmf}, 64'h0_0001);
    reg_write(13'h0800, {32'b0, 8'h00, 4'h2, 1'b0, 1'b0, 1'b0, 17'h1_FFFF});
    xlate(32'hFFFF_FFFF);
    chk("R9 direct addr wrap", {16'b0, xl_addr_o},
        {16'b0, (48'h1_FFFF << 31) + 48'h7FFF_FFFF + BASE});
  endtask

  task automatic t_timing;
    @(negedge clk);
    @(negedge clk);
    chk("R10 no req no vld", {63'b0, xl_vld}, 64'd0);
    @(negedge clk);
    xl_req = 1'b1; xl_addr = 32'h1234_5678;
    @(negedge clk);
    xl_req = 1'b0;
    chk("R10 vld after req", {63'b0, xl_vld}, 64'd1);
    @(negedge clk);
    chk("R10 vld drops", {63'b0, xl_vld}, 64'd0);
  endtask

  task automatic t_collide;
    reg_write(13'h0048, mk_ent(16'h0, 36'h111, 4'h3, 5'b00001));
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 13'h0048; reg_wdata = mk_ent(16'h0, 36'h222, 4'hC, 5'b00001);
    xl_req = 1'b1; xl_addr = 32'h4000_9004;
    @(negedge clk);
    reg_wr = 1'b0; xl_req = 1'b0;
    chk("R11 same-cycle old tgt", {60'b0, xl_tgt}, 64'h3);
    chk("R11 same-cycle old addr", {16'b0, xl_addr_o}, {16'b0, 36'h111, 12'h004});
    xlate(32'h4000_9004);
    chk("R11 next sees new", {16'b0, xl_addr_o}, {16'b0, 36'h222, 12'h004});
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 13'h0800; reg_wdata = {40'b0, 4'h9, 3'b000, 17'h0};
    xl_req = 1'b1; xl_addr = 32'h8000_0000;
    @(negedge clk);
    reg_wr = 1'b0; xl_req = 1'b0;
    chk("R11 direct same-cycle old", {60'b0, xl_tgt}, 64'h2);
    xlate(32'h8000_0000);
    chk("R11 direct next new", {12'b0, xl_tgt, xl_addr_o}, {12'b0, 4'h9, BASE});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_reg_rw;
    t_local;
    t_mapped;
    t_direct;
    t_timing;
    t_collide;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule